// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This unit sits beside the fetch stage of a small CPU and arbitrates eight interrupt request lines. Each line is watched for a low-to-high transition; a transition on an enabled line becomes a pending event. Among the pending normal events the unit always serves the lowest-numbered one first. When the CPU reports an instruction boundary or a halted state, the unit issues a one-cycle take strobe together with a jump target and a return-address value. The jump target comes from a bank of eight vector registers. The return-address value is the current PC with bit 0 forced high. After a normal dispatch, further dispatch waits until the CPU reports an interrupt return. Events that arrive during that wait are still recorded.

A separate control word holds a per-source enable and a per-source wake-up mark. A source marked for wake-up never calls a handler. Its event releases a halted CPU through a wake strobe, and it is simply dropped when the CPU is running. Wake-up events are served even while a normal handler is active. A vector whose bit 0 is set is treated as non-returnable: taking it does not start the wait for a return, so the next pending event can follow on the next cycle.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset the control readback is zero, every source is disabled, and neither take_o nor wake_o is asserted.
- R2: Control bits 7:0 enable sources 7:0 and bits 15:8 mark sources 7:0 as wake-up sources. Bits above 15 are not stored and always read back as zero.
- R3: Only a 0-to-1 transition of a request line creates an event. A line held high creates no further events, and a 1-to-0 transition creates none.
- R4: A transition on a source that is disabled in that cycle is dropped and is never dispatched, even after the source is later enabled.
- R5: When several normal events are pending, the lowest source index is dispatched first.
- R6: On a take, target_o equals the vector register of the selected source and ret_addr_o equals cpu_pc_i with bit 0 set to 1.
- R7: After taking a vector whose bit 0 is 0, no take occurs until cpu_iret_i is pulsed. Transitions during that time stay pending and are dispatched afterwards, highest priority first.
- R8: A wake-up event arriving while cpu_halted_i is high produces a one-cycle wake_o and no take.
- R9: A wake-up event arriving while the CPU is running has no effect. It is discarded and produces neither wake_o nor a take, even after the CPU halts.
- R10: Wake-up events are served while a normal handler is active and dispatch is deferred.
- R11: Taking a vector whose bit 0 is 1 does not defer dispatch, so another pending event is taken on the next cycle.
- R12: take_o is asserted only in cycles where cpu_ready_i or cpu_halted_i is high. A pending event waits for such a cycle.
- R13: A pending event is cleared in the cycle it is taken. A new transition on the same source in that cycle keeps it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Request lines, synchronous to clk_i |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control write data: [7:0] enables, [15:8] wake-up marks |
| ctrl_o | output | 32 | Control readback, upper bits zero |
| vec_we_i | input | 1 | Vector register write strobe |
| vec_sel_i | input | 3 | Vector register index for the write |
| vec_wdata_i | input | 32 | Vector write data |
| cpu_ready_i | input | 1 | CPU is at an instruction boundary |
| cpu_halted_i | input | 1 | CPU is halted |
| cpu_iret_i | input | 1 | CPU executed an interrupt return (one cycle) |
| cpu_pc_i | input | 32 | Current PC |
| take_o | output | 1 | Dispatch strobe, one cycle |
| target_o | output | 32 | Handler address, valid with take_o |
| ret_addr_o | output | 32 | Value to save as the return address, valid with take_o |
| wake_o | output | 1 | Halt release strobe |

## Verification
The properties assume that cpu_iret_i is a single-cycle pulse and that all inputs are synchronous to the clock. They do not require the ready and halted flags to be exclusive. They also assume nothing about when a handler returns, because deferral is judged only one cycle after a returnable take. The stimulus changes every input on the falling edge, pulses the return input for exactly one cycle and only while a returnable handler is active, and holds the vectors and the control word stable while an event is in flight. The expected sequence of takes and wakes therefore follows only from edge order, priority and deferral.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    DISP_IDLE = 1'b0,
    DISP_BUSY = 1'b1
  } disp_state_e;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] req_q, rise;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      pend_o <= '0;
    end else begin
      req_q  <= req_i;
      // a new edge wins over a same-cycle clear
      pend_o <= (pend_o & ~clr_i) | (rise & en_i);
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  output logic [N_SRC-1:0] gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  logic [N_SRC:0] seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N_SRC; i++) begin : g_chain
    assign seen[i+1] = seen[i] | req_i[i];
    assign gnt_o[i]  = req_i[i] & ~seen[i];
  end
  assign vld_o = seen[N_SRC];

  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_vec_bank.sv
module irq_vec_bank #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wsel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  rsel_i,
  output logic [ADDR_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] vec_q [N_SRC];

  for (genvar i = 0; i < N_SRC; i++) begin : g_vec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          vec_q[i] <= '0;
      else if (we_i && wsel_i == IDX_W'(i)) vec_q[i] <= wdata_i;
    end
  end

  assign rdata_o = vec_q[rsel_i];
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CTRL_W = 32,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  input  logic              vec_we_i,
  input  logic [IDX_W-1:0]  vec_sel_i,
  input  logic [ADDR_W-1:0] vec_wdata_i,
  input  logic              cpu_ready_i,
  input  logic              cpu_halted_i,
  input  logic              cpu_iret_i,
  input  logic [ADDR_W-1:0] cpu_pc_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic              wake_o
);
  logic [N_SRC-1:0] en_q, wk_q, pend, wake_pend, norm_pend, gnt, clr;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_vld;
  disp_state_e      state_q;
  logic             unused_bits;

  assign unused_bits = cpu_pc_i[0] ^ (^ctrl_wdata_i[CTRL_W-1:2*N_SRC]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      wk_q <= '0;
    end else if (ctrl_we_i) begin
      en_q <= ctrl_wdata_i[N_SRC-1:0];
      wk_q <= ctrl_wdata_i[2*N_SRC-1:N_SRC];
    end
  end

  assign ctrl_o = CTRL_W'({wk_q, en_q});

  irq_edge_latch #(.N_SRC(N_SRC)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (irq_i),
    .en_i   (en_q),
    .clr_i  (clr),
    .pend_o (pend)
  );

  assign wake_pend = pend & wk_q;
  assign norm_pend = pend & ~wk_q & en_q;

  irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
    .req_i (norm_pend),
    .gnt_o (gnt),
    .idx_o (sel_idx),
    .vld_o (sel_vld)
  );

  irq_vec_bank #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_vecs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (vec_we_i),
    .wsel_i  (vec_sel_i),
    .wdata_i (vec_wdata_i),
    .rsel_i  (sel_idx),
    .rdata_o (target_o)
  );

  assign take_o     = (state_q == DISP_IDLE) && (cpu_ready_i || cpu_halted_i) && sel_vld;
  assign ret_addr_o = {cpu_pc_i[ADDR_W-1:1], 1'b1};
  assign wake_o     = cpu_halted_i && (|wake_pend);
  // wake events are consumed every cycle, halted or not
  assign clr        = (take_o ? gnt : '0) | wake_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= DISP_IDLE;
    else begin
      unique case (state_q)
        DISP_IDLE: if (take_o && !target_o[0]) state_q <= DISP_BUSY;
        DISP_BUSY: if (cpu_iret_i)             state_q <= DISP_IDLE;
        default:                               state_q <= DISP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              take_o,
  input logic              wake_o,
  input logic [ADDR_W-1:0] target_o,
  input logic [ADDR_W-1:0] ret_addr_o,
  input logic [ADDR_W-1:0] cpu_pc_i,
  input logic              cpu_ready_i,
  input logic              cpu_halted_i,
  input logic [N_SRC-1:0]  gnt_i
);
  p_take_gated_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (cpu_ready_i || cpu_halted_i));

  p_ret_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (ret_addr_o[0] && ret_addr_o[ADDR_W-1:1] == cpu_pc_i[ADDR_W-1:1]));

  p_defer_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !target_o[0]) |=> !take_o);

  p_wake_halted_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> cpu_halted_i);

  p_single_grant_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_i));
endmodule

bind irq_vector_unit irq_vector_unit_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .take_o       (take_o),
  .wake_o       (wake_o),
  .target_o     (target_o),
  .ret_addr_o   (ret_addr_o),
  .cpu_pc_i     (cpu_pc_i),
  .cpu_ready_i  (cpu_ready_i),
  .cpu_halted_i (cpu_halted_i),
  .gnt_i        (gnt)
);

// File: tb/tb_irq_vector_unit.sv
module tb_irq_vector_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  irq_i = '0;
  logic        ctrl_we_i = 1'b0;
  logic [31:0] ctrl_wdata_i = '0;
  logic [31:0] ctrl_o;
  logic        vec_we_i = 1'b0;
  logic [2:0]  vec_sel_i = '0;
  logic [31:0] vec_wdata_i = '0;
  logic        cpu_ready_i = 1'b0;
  logic        cpu_halted_i = 1'b0;
  logic        cpu_iret_i = 1'b0;
  logic [31:0] cpu_pc_i = 32'h2000_0010;
  logic        take_o, wake_o;
  logic [31:0] target_o, ret_addr_o;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R1";

  bit          q_wake[$];
  logic [31:0] q_tgt[$];
  logic [31:0] q_ret[$];
  string       q_tag[$];
  logic [31:0] vmodel [8];

  always #2 clk_i = ~clk_i;

  irq_vector_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i), .ctrl_o(ctrl_o),
    .vec_we_i(vec_we_i), .vec_sel_i(vec_sel_i), .vec_wdata_i(vec_wdata_i),
    .cpu_ready_i(cpu_ready_i), .cpu_halted_i(cpu_halted_i), .cpu_iret_i(cpu_iret_i),
    .cpu_pc_i(cpu_pc_i), .take_o(take_o), .target_o(target_o),
    .ret_addr_o(ret_addr_o), .wake_o(wake_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    @(negedge clk_i); ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk_i); ctrl_we_i = 1'b0;
  endtask

  task automatic wr_vec(input int i, input logic [31:0] v);
    @(negedge clk_i); vec_we_i = 1'b1; vec_sel_i = 3'(i); vec_wdata_i = v;
    @(negedge clk_i); vec_we_i = 1'b0;
    vmodel[i] = v;
  endtask

  task automatic exp_take(input int src, input string tag);
    q_wake.push_back(1'b0);
    q_tgt.push_back(vmodel[src]);
    q_ret.push_back({cpu_pc_i[31:1], 1'b1});
    q_tag.push_back(tag);
  endtask

  task automatic exp_wake(input string tag);
    q_wake.push_back(1'b1); q_tgt.push_back('0); q_ret.push_back('0); q_tag.push_back(tag);
  endtask

  task automatic pulse_iret;
    @(negedge clk_i); cpu_iret_i = 1'b1;
    @(negedge clk_i); cpu_iret_i = 1'b0;
  endtask

  task automatic drain(input string tag);
    check(q_wake.size() == 0, tag, "outstanding expected events", 32'(q_wake.size()), 32'd0);
    q_wake.delete(); q_tgt.delete(); q_ret.delete(); q_tag.delete();
  endtask

  task automatic consume(input bit is_wake);
    string tg;
    if (q_wake.size() == 0) begin
      check(1'b0, cur_tag, is_wake ? "unexpected wake" : "unexpected take",
            is_wake ? 32'd1 : target_o, 32'd0);
    end else begin
      tg = q_tag.pop_front();
      if (q_wake.pop_front() != is_wake) begin
        check(1'b0, tg, "event kind", 32'(is_wake), 32'(!is_wake));
        void'(q_tgt.pop_front()); void'(q_ret.pop_front());
      end else if (is_wake) begin
        check(1'b1, tg, "wake", 32'd1, 32'd1);
        void'(q_tgt.pop_front()); void'(q_ret.pop_front());
      end else begin
        logic [31:0] et, er;
        et = q_tgt.pop_front(); er = q_ret.pop_front();
        check(target_o == et, tg, "target", target_o, et);
        check(ret_addr_o == er, tg, "return value", ret_addr_o, er);
      end
    end
  endtask

  // monitor: samples 1 ns before each rising edge
  initial forever begin
    @(negedge clk_i); #1;
    if (rst_ni) begin
      if (take_o) consume(1'b0);
      if (wake_o) consume(1'b1);
    end
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    check(1'b0, "watchdog", "run did not finish", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(2);
    // R1: reset state
    check(ctrl_o == 32'h0, "R1", "ctrl after reset", ctrl_o, 32'h0);
    check(take_o == 1'b0, "R1", "take after reset", 32'(take_o), 32'h0);
    check(wake_o == 1'b0, "R1", "wake after reset", 32'(wake_o), 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) wr_vec(i, 32'h1000 + 32'(i) * 32'h100);

    // R2: reserved control bits read zero
    cur_tag = "R2";
    wr_ctrl(32'hFFFF_FFFF);
    check(ctrl_o == 32'h0000_FFFF, "R2", "ctrl readback", ctrl_o, 32'h0000_FFFF);
    wr_ctrl(32'h0000_00FF);
    check(ctrl_o == 32'h0000_00FF, "R2", "ctrl readback", ctrl_o, 32'h0000_00FF);

    // R5/R6/R7: priority, return value, deferral with late edge on source 1
    cur_tag = "R5";
    cpu_ready_i = 1'b1;
    exp_take(2, "R5");
    @(negedge clk_i); irq_i = 8'h24;
    tick(2);
    cur_tag = "R7";
    irq_i = 8'h26;                 // source 1 rises while deferred
    tick(3);
    cpu_pc_i = 32'h3000_0020;
    exp_take(1, "R7");
    pulse_iret();
    tick(2);
    exp_take(5, "R6");
    pulse_iret();
    tick(2);
    pulse_iret();
    irq_i = 8'h00;
    tick(3);
    drain("R7");

    // R3: held level creates one event only
    cur_tag = "R3";
    exp_take(0, "R3");
    irq_i = 8'h01;
    tick(2);
    pulse_iret();
    tick(4);
    irq_i = 8'h00;
    tick(3);
    drain("R3");

    // R4: edge while disabled is dropped
    cur_tag = "R4";
    wr_ctrl(32'h0000_00FE);
    @(negedge clk_i); irq_i = 8'h01;
    tick(2); irq_i = 8'h00;
    wr_ctrl(32'h0000_00FF);
    tick(4);
    drain("R4");

    // R12: no take until ready or halted
    cur_tag = "R12";
    cpu_ready_i = 1'b0;
    @(negedge clk_i); irq_i = 8'h10;
    tick(3);
    exp_take(4, "R12");
    cpu_ready_i = 1'b1;
    tick(2);
    drain("R12");
    pulse_iret();
    irq_i = 8'h00;

    // R8: wake while halted
    cur_tag = "R8";
    wr_ctrl(32'h0000_40FF);
    cpu_ready_i = 1'b0; cpu_halted_i = 1'b1;
    exp_wake("R8");
    @(negedge clk_i); irq_i = 8'h40;
    tick(3);
    drain("R8");
    irq_i = 8'h00;

    // R9: wake while running is discarded
    cur_tag = "R9";
    cpu_halted_i = 1'b0; cpu_ready_i = 1'b1;
    @(negedge clk_i); irq_i = 8'h40;
    tick(2);
    cpu_halted_i = 1'b1;
    tick(3);
    drain("R9");
    cpu_halted_i = 1'b0; irq_i = 8'h00;

    // R10: wake served during an active handler
    cur_tag = "R10";
    exp_take(3, "R10");
    @(negedge clk_i); irq_i = 8'h08;
    tick(2);
    cpu_halted_i = 1'b1;
    exp_wake("R10");
    irq_i = 8'h48;
    tick(3);
    drain("R10");
    cpu_halted_i = 1'b0;
    pulse_iret();
    irq_i = 8'h00;

    // R11: non-returnable vector lets the next one through
    cur_tag = "R11";
    wr_vec(2, 32'h0000_1201);
    exp_take(2, "R11");
    exp_take(5, "R11");
    @(negedge clk_i); irq_i = 8'h24;
    tick(3);
    drain("R11");
    pulse_iret();
    irq_i = 8'h00;

    // R13: edge in the take cycle keeps the event pending
    cur_tag = "R13";
    wr_vec(3, 32'h0000_1301);
    cpu_ready_i = 1'b0;
    @(negedge clk_i); irq_i = 8'h08;
    @(negedge clk_i); irq_i = 8'h00;
    exp_take(3, "R13");
    exp_take(3, "R13");
    @(negedge clk_i); irq_i = 8'h08; cpu_ready_i = 1'b1;
    tick(4);
    drain("R13");
    irq_i = 8'h00;
    tick(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule